// File: doc/BRIEF.md
# Two-Input Conditional Output Toggler

The block holds a two-bit state and shows it at its outputs straight from flip-flops. Each state bit has a partner input with the same index. On each rising clock edge where the enable is high, the block looks at the two inputs and at whether the two state bits currently match. From these it decides which state bits to invert.

The rules are as follows. If both inputs are high, both bits invert. If both inputs are low, neither bit changes. If exactly one input is high, the outcome depends on the current state. When the two bits match, the bit whose partner input is low inverts. When the two bits differ, the bit whose partner input is high inverts. A bit that is not chosen keeps its value.

Reset is asynchronous and active low, and it clears the state at once. The block then releases reset internally through a two-stage synchronizer, so the first state update comes on the third rising edge after the reset input goes high.

Top module: `pair_toggler`

## Requirements
- R1: With `en` high and `sel_in` = 2'b11 at a rising edge, both bits of `q_out` invert.
- R2: With `en` high and `sel_in` = 2'b00 at a rising edge, `q_out` keeps its value.
- R3: With `en` high, exactly one `sel_in` bit high, and `q_out[0]` equal to `q_out[1]`, the `q_out` bit whose same-index `sel_in` bit is 0 inverts and the other bit holds (for example 2'b00 with `sel_in` 2'b01 becomes 2'b10).
- R4: With `en` high, exactly one `sel_in` bit high, and `q_out[0]` different from `q_out[1]`, the `q_out` bit whose same-index `sel_in` bit is 1 inverts and the other bit holds.
- R5: The match test in R3 and R4 uses the `q_out` value from before the edge, not the value being computed at that edge.
- R6: With `en` low, `q_out` keeps its value whatever `sel_in` is.
- R7: Driving `rst_n` low forces `q_out` to 2'b00 at once, without waiting for a clock edge, and keeps it there regardless of `en` and `sel_in`.
- R8: After `rst_n` goes high, `q_out` stays 2'b00 through the first two rising edges, and the first update takes place on the third rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all updates take place on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en | input | 1 | Clock enable for the state update |
| sel_in | input | 2 | Control inputs; bit i is the partner of `q_out[i]` |
| q_out | output | 2 | Registered state |

## Verification
Two things can coincide in a single cycle: the choice of which bit to flip, which depends on the state, and the change of that same state. A wrong design would make the choice from the freshly computed value instead of the stored one. The vector table therefore applies the same one-hot input on consecutive edges, so that the match test gives a different answer at each edge. The expected values come from the previous stored state alone.

Reset can also coincide with active toggling inputs. The bench asserts reset while `en` is high and `sel_in` is 2'b11, then releases it under the same inputs. It checks that nothing moves until the third rising edge.

// File: rtl/pair_toggler_pkg.sv
package pair_toggler_pkg;
  localparam int NBITS       = 2;
  localparam int SYNC_STAGES = 2;
  typedef logic [NBITS-1:0] pair_t;
endpackage

// File: rtl/pair_rst_sync.sv
module pair_rst_sync #(
  parameter int STAGES = pair_toggler_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/pair_flip_decide.sv
module pair_flip_decide
  import pair_toggler_pkg::*;
(
  input  pair_t sel_in,
  input  pair_t cur_q,
  output pair_t flip_mask
);
  logic match;

  always_comb begin
    match = (cur_q[0] == cur_q[1]);
    case (sel_in)
      2'b11:   flip_mask = 2'b11;
      2'b01,
      2'b10:   flip_mask = match ? ~sel_in : sel_in;
      default: flip_mask = 2'b00;
    endcase
  end
endmodule

// File: rtl/pair_state_reg.sv
module pair_state_reg
  import pair_toggler_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  pair_t flip_mask,
  output pair_t state_q
);
  pair_t state_d;

  always_comb begin
    state_d = state_q;
    if (en) state_d = state_q ^ flip_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= '0;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/pair_toggler.sv
module pair_toggler
  import pair_toggler_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [NBITS-1:0] sel_in,
  output logic [NBITS-1:0] q_out
);
  logic  rst_sync_n;
  pair_t flip_mask;
  pair_t state_q;

  pair_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pair_flip_decide u_decide (
    .sel_in    (sel_in),
    .cur_q     (state_q),
    .flip_mask (flip_mask)
  );

  pair_state_reg u_state (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (en),
    .flip_mask (flip_mask),
    .state_q   (state_q)
  );

  assign q_out = state_q;
endmodule

// File: rtl/pair_toggler_chk.sv
module pair_toggler_chk (
  input logic       clk,
  input logic       rst_ok_n,
  input logic       en,
  input logic [1:0] sel_in,
  input logic [1:0] q_out
);
  // R1
  a_r1_both_high_invert: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (en && sel_in == 2'b11) |=> (q_out == ~$past(q_out)));

  // R2
  a_r2_both_low_hold: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (en && sel_in == 2'b00) |=> $stable(q_out));

  // R3, R5
  a_r3_match_flips_idle_side: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (en && $countones(sel_in) == 1 && q_out[0] == q_out[1])
      |=> (q_out == ($past(q_out) ^ ~$past(sel_in))));

  // R4, R5
  a_r4_differ_flips_active_side: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (en && $countones(sel_in) == 1 && q_out[0] != q_out[1])
      |=> (q_out == ($past(q_out) ^ $past(sel_in))));

  // R6
  a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!en) |=> $stable(q_out));

  // R7, R8
  a_r7_reset_clears: assert property (@(posedge clk)
    (!rst_ok_n) |=> (q_out == 2'b00));
endmodule

bind pair_toggler pair_toggler_chk u_chk (
  .clk      (clk),
  .rst_ok_n (rst_sync_n),
  .en       (en),
  .sel_in   (sel_in),
  .q_out    (q_out)
);

// File: tb/tb_pair_toggler.sv
module tb_pair_toggler;
  logic       clk;
  logic       rst_n;
  logic       en;
  logic [1:0] sel_in;
  logic [1:0] q_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  pair_toggler dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (en),
    .sel_in (sel_in),
    .q_out  (q_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // {en, sel_in[1:0], expected q_out[1:0]}, walked from q_out = 2'b00
  localparam int NVEC = 14;
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1_00_00, // R2
    5'b1_11_11, // R1
    5'b1_01_01, // R3 equal
    5'b1_01_00, // R4 differ, R5
    5'b1_10_01, // R3
    5'b1_10_11, // R4, R5
    5'b0_11_11, // R6
    5'b1_10_10, // R3 from 11
    5'b1_01_11, // R4
    5'b1_11_00, // R1
    5'b0_01_00, // R6
    5'b1_01_10, // R3
    5'b1_10_00, // R4
    5'b1_00_00  // R2
  };

  task automatic check(input logic [1:0] exp, input string req);
    n_checks++;
    if (q_out !== exp) begin
      n_fail++;
      $display("FAIL %s: q_out=%b expected=%b", req, q_out, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    rst_n  = 1'b0;
    en     = 1'b0;
    sel_in = 2'b00;
    repeat (3) @(negedge clk);
    check(2'b00, "R7 reset state");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(2'b00, "R8 idle after release");

    for (int i = 0; i < NVEC; i++) begin
      en     = VEC[i][4];
      sel_in = VEC[i][3:2];
      @(negedge clk);
      check(VEC[i][1:0], $sformatf("R1-R6 table vector %0d", i));
    end

    // R7: asynchronous clear while toggling inputs are active
    en = 1'b1; sel_in = 2'b11;
    @(negedge clk);
    check(2'b11, "R1 before reset");
    #1 rst_n = 1'b0;
    #0.5;
    check(2'b00, "R7 immediate clear");
    @(negedge clk);
    check(2'b00, "R7 held under en and 11");

    // R8: release with toggling inputs still applied
    rst_n = 1'b1;
    @(negedge clk);
    check(2'b00, "R8 first edge after release");
    @(negedge clk);
    check(2'b00, "R8 second edge after release");
    @(negedge clk);
    check(2'b11, "R8 third edge updates");

    en = 1'b0;
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      finish_run();
    end
  end
endmodule